// File: doc/BRIEF.md
# Shared-Storage Virtual-Channel Input Buffer

This block is the flit store for one input port of a network router. Several virtual channels share one synchronous RAM: each channel owns a fixed region of slots inside it, and the RAM address is the channel number concatenated with that channel's slot pointer. Each channel keeps its own read and write pointers. Both pointers are one bit wider than the slot index, so a full channel and an empty channel can be told apart.

The upstream link writes one flit per cycle, tagged with a channel number and with head and tail marks. The switch allocator pops one flit per cycle by naming a channel, and the flit appears one cycle later. The block reports the following for every channel:
- whether the channel is empty;
- the head and tail marks of the flit waiting at the front of the channel;
- whether the channel may be handed to a new packet upstream.

A parameter sets the reallocation rule. In atomic mode a channel is handed out again only when it is drained. In non-atomic mode it is handed out as soon as the tail of its current packet has arrived. With one channel the block is a plain FIFO input buffer.

Top module: `vcbuf_shared`

## Requirements
- R1: After reset every channel is empty, every channel is free, the overflow flag is 0 and `rd_valid` is 0.
- R2: A pop of a non-empty channel, sampled at a clock edge, presents that channel's oldest flit on `rd_data` during the following cycle, with `rd_valid` at 1 and `rd_head` and `rd_tail` at 1 exactly when that flit was written with those marks. Flits leave each channel in the order they were written.
- R3: Every channel holds `SLOTS` flits of its own. Filling one channel does not refuse a write to any other channel.
- R4: A pop naming an empty channel, or a channel number of `NUM_VC` or above, is ignored: `rd_valid` stays 0 in the next cycle and no channel changes.
- R5: A write to a full channel is dropped and leaves that channel's contents unchanged. It sets `overflow`, which stays at 1 until reset.
- R6: `vc_empty[i]` is 1 exactly when channel i holds no flit. A write becomes visible in the cycle after its clock edge.
- R7: `vc_hol_head[i]` and `vc_hol_tail[i]` give the marks of the flit at the front of channel i. This holds when the channel holds the tail of one packet followed by the head of the next.
- R8: With `ATOMIC=1`, `vc_free[i]` is 1 exactly when channel i is empty and no packet is open in it. A packet is open from its head flit until its tail flit is written.
- R9: With `ATOMIC=0`, `vc_free[i]` is 1 exactly when no packet is open in channel i. This means that the last accepted flit carrying a head or tail mark had a tail mark, or that nothing has been written since reset. Flits may still be waiting in the channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Write a flit this cycle |
| wr_vc | input | VC_W | Channel number of the written flit |
| wr_data | input | FLIT_W | Flit payload |
| wr_head | input | 1 | Written flit starts a packet |
| wr_tail | input | 1 | Written flit ends a packet |
| rd_en | input | 1 | Pop a flit this cycle |
| rd_vc | input | VC_W | Channel number to pop |
| rd_valid | output | 1 | `rd_data` carries a popped flit |
| rd_data | output | FLIT_W | Popped flit payload |
| rd_head | output | 1 | Head mark of the popped flit |
| rd_tail | output | 1 | Tail mark of the popped flit |
| vc_empty | output | NUM_VC | Per-channel empty flags |
| vc_hol_head | output | NUM_VC | Head mark of each channel's front flit |
| vc_hol_tail | output | NUM_VC | Tail mark of each channel's front flit |
| vc_free | output | NUM_VC | Channel may be reallocated upstream |
| overflow | output | 1 | Sticky flag: a write reached a full channel |

## Verification
The assertions assume that the allocator pops only channels it sees as non-empty. They also assume that flits with head and tail marks arrive in head-then-tail order within a channel, because the open-packet tracking follows the marks it receives. Pops of empty channels and writes to full channels are still legal inputs: the stimulus issues them on purpose to exercise R4 and R5. The random traffic generator tracks whether a packet is open per channel, so the head and tail marks it emits always form well-ordered packets. Single-flit packets that carry both marks at once are included.

// File: rtl/vcbuf_pkg.sv
package vcbuf_pkg;

   // Packet-position marks carried beside every stored flit
   typedef struct packed {
      logic head;
      logic tail;
   } flit_kind_t;

   // Index width that stays at least one bit for single-entry structures
   function automatic int idx_width(input int n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction

endpackage

// File: rtl/vcbuf_ram.sv
module vcbuf_ram #(
   parameter int DATA_W = 32,
   parameter int DEPTH  = 16,
   parameter int ADDR_W = 4
) (
   input  logic              clk,
   input  logic              we,
   input  logic [ADDR_W-1:0] waddr,
   input  logic [DATA_W-1:0] wdata,
   input  logic              re,
   input  logic [ADDR_W-1:0] raddr,
   output logic [DATA_W-1:0] rdata
);

   if ((1 << ADDR_W) < DEPTH) begin : g_bad_addr
      $error("vcbuf_ram: ADDR_W too narrow for DEPTH");
   end

   logic [DATA_W-1:0] mem [DEPTH];

   // Synchronous write, registered read: one cycle of read latency
   always_ff @(posedge clk) begin
      if (we) mem[waddr] <= wdata;
      if (re) rdata <= mem[raddr];
   end

endmodule

// File: rtl/vcbuf_vc_ctrl.sv
module vcbuf_vc_ctrl
   import vcbuf_pkg::*;
#(
   parameter int SLOTS = 4,
   localparam int PTR_W = idx_width(SLOTS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             push,
   input  logic             pop,
   input  flit_kind_t       kind_in,
   output logic             empty,
   output logic             full,
   output logic [PTR_W-1:0] wr_slot,
   output logic [PTR_W-1:0] rd_slot,
   output flit_kind_t       hol_kind
);

   logic [PTR_W:0] wptr_q, rptr_q;
   flit_kind_t     kinds_q [SLOTS];

   assign wr_slot = wptr_q[PTR_W-1:0];
   assign rd_slot = rptr_q[PTR_W-1:0];
   assign empty   = (wptr_q == rptr_q);
   assign full    = (wptr_q[PTR_W] != rptr_q[PTR_W]) && (wr_slot == rd_slot);
   assign hol_kind = kinds_q[rd_slot];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wptr_q <= '0;
         rptr_q <= '0;
         for (int i = 0; i < SLOTS; i++) kinds_q[i] <= '0;
      end else begin
         if (push) begin
            wptr_q           <= wptr_q + 1'b1;
            kinds_q[wr_slot] <= kind_in;
         end
         if (pop) rptr_q <= rptr_q + 1'b1;
      end
   end

   // R5: the top never pushes into a full channel
   p_no_overflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
      full |-> !push);
   // R4: the top never pops an empty channel
   p_no_underflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
      empty |-> !pop);
   // R3: occupancy never exceeds the channel region
   p_occupancy_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (wptr_q - rptr_q) <= (PTR_W+1)'(SLOTS));
   // R6: a push into an empty channel without a pop makes it non-empty
   p_push_fills_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (push && !pop) |=> !empty);

endmodule

// File: rtl/vcbuf_realloc.sv
module vcbuf_realloc
   import vcbuf_pkg::*;
#(
   parameter bit ATOMIC = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       push,
   input  flit_kind_t kind_in,
   input  logic       empty,
   output logic       free
);

   logic open_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                       open_q <= 1'b0;
      else if (push && kind_in.tail)    open_q <= 1'b0;
      else if (push && kind_in.head)    open_q <= 1'b1;
   end

   if (ATOMIC) begin : g_atomic
      assign free = !open_q && empty;
      // R8: an atomic channel is never offered while it holds flits
      p_free_empty_r8: assert property (@(posedge clk) disable iff (!rst_n)
         free |-> empty);
   end else begin : g_nonatomic
      assign free = !open_q;
      // R9: a tail write releases the channel in the next cycle
      p_tail_frees_r9: assert property (@(posedge clk) disable iff (!rst_n)
         (push && kind_in.tail) |=> free);
   end

endmodule

// File: rtl/vcbuf_shared.sv
module vcbuf_shared
   import vcbuf_pkg::*;
#(
   parameter int NUM_VC = 4,
   parameter int SLOTS  = 4,
   parameter int FLIT_W = 32,
   parameter bit ATOMIC = 1'b1,
   localparam int VC_W  = idx_width(NUM_VC)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [VC_W-1:0]   wr_vc,
   input  logic [FLIT_W-1:0] wr_data,
   input  logic              wr_head,
   input  logic              wr_tail,
   input  logic              rd_en,
   input  logic [VC_W-1:0]   rd_vc,
   output logic              rd_valid,
   output logic [FLIT_W-1:0] rd_data,
   output logic              rd_head,
   output logic              rd_tail,
   output logic [NUM_VC-1:0] vc_empty,
   output logic [NUM_VC-1:0] vc_hol_head,
   output logic [NUM_VC-1:0] vc_hol_tail,
   output logic [NUM_VC-1:0] vc_free,
   output logic              overflow
);

   localparam int PTR_W  = idx_width(SLOTS);
   localparam int ADDR_W = VC_W + PTR_W;
   localparam int DEPTH  = NUM_VC * SLOTS;

   if (NUM_VC < 1) begin : g_bad_vc
      $error("vcbuf_shared: NUM_VC must be at least 1");
   end
   if (SLOTS < 2 || (SLOTS & (SLOTS - 1)) != 0) begin : g_bad_slots
      $error("vcbuf_shared: SLOTS must be a power of two, at least 2");
   end
   if (FLIT_W < 1) begin : g_bad_width
      $error("vcbuf_shared: FLIT_W must be positive");
   end

   flit_kind_t       kind_in;
   logic [NUM_VC-1:0] wr_sel, rd_sel, push_v, pop_v, full_v;
   logic [PTR_W-1:0]  wslot_v [NUM_VC];
   logic [PTR_W-1:0]  rslot_v [NUM_VC];
   flit_kind_t        hol_v   [NUM_VC];

   assign kind_in = '{head: wr_head, tail: wr_tail};

   for (genvar i = 0; i < NUM_VC; i++) begin : g_vc
      assign wr_sel[i] = wr_en && (wr_vc == VC_W'(i));
      assign rd_sel[i] = rd_en && (rd_vc == VC_W'(i));
      assign push_v[i] = wr_sel[i] && !full_v[i];
      assign pop_v[i]  = rd_sel[i] && !vc_empty[i];

      vcbuf_vc_ctrl #(.SLOTS(SLOTS)) u_ctrl (
         .clk      (clk),
         .rst_n    (rst_n),
         .push     (push_v[i]),
         .pop      (pop_v[i]),
         .kind_in  (kind_in),
         .empty    (vc_empty[i]),
         .full     (full_v[i]),
         .wr_slot  (wslot_v[i]),
         .rd_slot  (rslot_v[i]),
         .hol_kind (hol_v[i])
      );

      vcbuf_realloc #(.ATOMIC(ATOMIC)) u_realloc (
         .clk     (clk),
         .rst_n   (rst_n),
         .push    (push_v[i]),
         .kind_in (kind_in),
         .empty   (vc_empty[i]),
         .free    (vc_free[i])
      );

      assign vc_hol_head[i] = hol_v[i].head;
      assign vc_hol_tail[i] = hol_v[i].tail;
   end

   // One-hot selects steer the shared pointers and marks
   logic [PTR_W-1:0] wslot_sel, rslot_sel;
   flit_kind_t       rkind_sel;
   logic             push_any, pop_any, ovf_hit;

   always_comb begin
      wslot_sel = '0;
      rslot_sel = '0;
      rkind_sel = '0;
      for (int i = 0; i < NUM_VC; i++) begin
         if (wr_sel[i]) wslot_sel |= wslot_v[i];
         if (rd_sel[i]) begin
            rslot_sel |= rslot_v[i];
            rkind_sel |= hol_v[i];
         end
      end
   end

   assign push_any = |push_v;
   assign pop_any  = |pop_v;
   assign ovf_hit  = |(wr_sel & full_v);

   vcbuf_ram #(.DATA_W(FLIT_W), .DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_ram (
      .clk   (clk),
      .we    (push_any),
      .waddr ({wr_vc, wslot_sel}),
      .wdata (wr_data),
      .re    (pop_any),
      .raddr ({rd_vc, rslot_sel}),
      .rdata (rd_data)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_valid <= 1'b0;
         rd_head  <= 1'b0;
         rd_tail  <= 1'b0;
         overflow <= 1'b0;
      end else begin
         rd_valid <= pop_any;
         if (pop_any) begin
            rd_head <= rkind_sel.head;
            rd_tail <= rkind_sel.tail;
         end
         if (ovf_hit) overflow <= 1'b1;
      end
   end

   // R5: once raised, the overflow flag holds until reset
   p_ovf_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
      overflow |=> overflow);
   // R5: a write aimed at a full channel raises the flag
   p_ovf_raise_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (|(wr_sel & full_v)) |=> overflow);
   // R2: a pop of a non-empty channel is answered in the next cycle
   p_pop_answer_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (|(rd_sel & ~vc_empty)) |=> rd_valid);
   // R4: without a serviceable pop there is no read result
   p_empty_pop_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !(|(rd_sel & ~vc_empty)) |=> !rd_valid);
   // R2: the switch allocator gets at most one channel per cycle
   p_single_pop_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(pop_v));

endmodule

// File: tb/vcbuf_shared_tb.sv
module vcbuf_shared_tb;

   localparam int NV    = 4;
   localparam int SL    = 4;
   localparam int FW    = 32;
   localparam int VW    = 2;

   typedef struct {
      logic [FW-1:0] data;
      logic          head;
      logic          tail;
   } mflit_t;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          wr_en = 1'b0, wr_head = 1'b0, wr_tail = 1'b0, rd_en = 1'b0;
   logic [VW-1:0] wr_vc = '0, rd_vc = '0;
   logic [FW-1:0] wr_data = '0;

   logic          a_rv, n_rv, a_rh, n_rh, a_rt, n_rt, a_ovf, n_ovf;
   logic [FW-1:0] a_rd, n_rd;
   logic [NV-1:0] a_emp, n_emp, a_hh, n_hh, a_ht, n_ht, a_free, n_free;

   always #2.5 clk = ~clk;

   // Non-atomic instance
   vcbuf_shared #(.NUM_VC(NV), .SLOTS(SL), .FLIT_W(FW), .ATOMIC(1'b0)) u_dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_vc(wr_vc), .wr_data(wr_data),
      .wr_head(wr_head), .wr_tail(wr_tail), .rd_en(rd_en), .rd_vc(rd_vc),
      .rd_valid(n_rv), .rd_data(n_rd), .rd_head(n_rh), .rd_tail(n_rt),
      .vc_empty(n_emp), .vc_hol_head(n_hh), .vc_hol_tail(n_ht),
      .vc_free(n_free), .overflow(n_ovf));

   // Atomic instance, same stimulus
   vcbuf_shared #(.NUM_VC(NV), .SLOTS(SL), .FLIT_W(FW), .ATOMIC(1'b1)) u_dut_at (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_vc(wr_vc), .wr_data(wr_data),
      .wr_head(wr_head), .wr_tail(wr_tail), .rd_en(rd_en), .rd_vc(rd_vc),
      .rd_valid(a_rv), .rd_data(a_rd), .rd_head(a_rh), .rd_tail(a_rt),
      .vc_empty(a_emp), .vc_hol_head(a_hh), .vc_hol_tail(a_ht),
      .vc_free(a_free), .overflow(a_ovf));

   // ---------------- reference model ----------------
   mflit_t q [NV][$];
   bit     m_open [NV];
   bit     m_ovf;
   bit     m_rv;
   mflit_t m_rd;

   always @(posedge clk) begin
      if (!rst_n) begin
         for (int v = 0; v < NV; v++) begin q[v].delete(); m_open[v] = 0; end
         m_ovf = 0;
         m_rv  = 0;
      end else begin
         int wsize;
         wsize = (wr_en) ? q[wr_vc].size() : 0;
         m_rv = 0;
         if (rd_en && q[rd_vc].size() > 0) begin
            m_rd = q[rd_vc].pop_front();
            m_rv = 1;
         end
         if (wr_en) begin
            if (wsize < SL) begin
               mflit_t f;
               f.data = wr_data; f.head = wr_head; f.tail = wr_tail;
               q[wr_vc].push_back(f);
               if (wr_tail)      m_open[wr_vc] = 0;
               else if (wr_head) m_open[wr_vc] = 1;
            end else begin
               m_ovf = 1;
            end
         end
      end
   end

   // ---------------- checking ----------------
   int checks = 0;
   int fails  = 0;

   task automatic chk(input string req, input string what, input longint act, input longint exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
      end
   endtask

   always @(negedge clk) begin
      if (rst_n) begin
         chk("R2/R4", "rd_valid(na)", n_rv, m_rv);
         chk("R2/R4", "rd_valid(at)", a_rv, m_rv);
         if (m_rv) begin
            chk("R2", "rd_data(na)", n_rd, m_rd.data);
            chk("R2", "rd_data(at)", a_rd, m_rd.data);
            chk("R2", "rd_head", n_rh, m_rd.head);
            chk("R2", "rd_tail", a_rt, m_rd.tail);
         end
         chk("R5", "overflow(na)", n_ovf, m_ovf);
         chk("R5", "overflow(at)", a_ovf, m_ovf);
         for (int v = 0; v < NV; v++) begin
            chk("R6", $sformatf("empty[%0d]", v), n_emp[v], q[v].size() == 0);
            chk("R6", $sformatf("empty_at[%0d]", v), a_emp[v], q[v].size() == 0);
            if (q[v].size() > 0) begin
               chk("R7", $sformatf("hol_head[%0d]", v), n_hh[v], q[v][0].head);
               chk("R7", $sformatf("hol_tail[%0d]", v), a_ht[v], q[v][0].tail);
            end
            chk("R9", $sformatf("free_na[%0d]", v), n_free[v], !m_open[v]);
            chk("R8", $sformatf("free_at[%0d]", v), a_free[v],
                !m_open[v] && q[v].size() == 0);
         end
      end
   end

   // ---------------- stimulus ----------------
   task automatic cyc(input logic we, input int wv, input logic h, input logic t,
                      input logic [FW-1:0] d, input logic re, input int rv);
      @(negedge clk);
      #0.5;
      wr_en = we; wr_vc = VW'(wv); wr_head = h; wr_tail = t; wr_data = d;
      rd_en = re; rd_vc = VW'(rv);
   endtask

   task automatic idle();
      cyc(1'b0, 0, 1'b0, 1'b0, '0, 1'b0, 0);
   endtask

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
   endtask

   bit gen_open [NV];

   initial begin
      repeat (3) @(negedge clk);
      // R1: reset state, sampled while reset is still asserted
      chk("R1", "empty", n_emp, {NV{1'b1}});
      chk("R1", "free_na", n_free, {NV{1'b1}});
      chk("R1", "free_at", a_free, {NV{1'b1}});
      chk("R1", "overflow", n_ovf, 0);
      chk("R1", "rd_valid", a_rv, 0);
      rst_n = 1'b1;
      idle();
      // R4: pop of an empty channel
      cyc(1'b0, 0, 0, 0, '0, 1'b1, 2);
      idle();
      idle();
      chk("R4", "pop empty rd_valid", n_rv, 0);
      // R3: fill channel 0 to capacity
      cyc(1, 0, 1, 0, 32'hA000_0000, 0, 0);
      cyc(1, 0, 0, 0, 32'hA000_0001, 0, 0);
      cyc(1, 0, 0, 0, 32'hA000_0002, 0, 0);
      cyc(1, 0, 0, 1, 32'hA000_0003, 0, 0);
      // R5: write into the full channel; R3: channel 1 still accepts
      cyc(1, 0, 1, 1, 32'hDEAD_BEEF, 0, 0);
      cyc(1, 1, 1, 1, 32'hB000_0000, 0, 0);
      cyc(1, 1, 1, 0, 32'hB000_0001, 0, 0);
      idle();
      idle();
      chk("R5", "overflow raised", n_ovf, 1);
      chk("R3", "vc1 nonempty", n_emp[1], 0);
      chk("R9", "non-atomic free with flits waiting", n_free[0], 1);
      chk("R8", "atomic not free while holding", a_free[0], 0);
      // R7: channel 1 holds a single-flit packet then an open head
      cyc(0, 0, 0, 0, '0, 1, 1);
      idle();
      idle();
      chk("R7", "hol head after pop", n_hh[1], 1);
      chk("R7", "hol tail after pop", n_ht[1], 0);
      // R2: drain channel 0 back to back
      for (int i = 0; i < SL; i++) cyc(0, 0, 0, 0, '0, 1, 0);
      idle();
      idle();
      chk("R2", "vc0 drained", n_emp[0], 1);
      chk("R5", "overflow stays", a_ovf, 1);
      cyc(1, 1, 0, 1, 32'hB000_0002, 0, 0);
      for (int i = 0; i < NV; i++) gen_open[i] = (i == 1) ? 0 : gen_open[i];
      // random well-formed traffic
      for (int n = 0; n < 4000; n++) begin
         int  wv, rv;
         logic we, re, h, t;
         wv = $urandom_range(NV - 1);
         rv = $urandom_range(NV - 1);
         we = ($urandom_range(99) < 55);
         re = ($urandom_range(99) < 50);
         h  = !gen_open[wv];
         t  = ($urandom_range(2) == 0);
         cyc(we, wv, h, t, $urandom(), re, rv);
         // the generator advances only when the write will be accepted
         if (we && (n_emp[wv] || q[wv].size() < SL)) begin
            if (t)      gen_open[wv] = 0;
            else if (h) gen_open[wv] = 1;
         end
      end
      for (int i = 0; i < 3 * NV * SL; i++) cyc(0, 0, 0, 0, '0, 1, i % NV);
      idle();
      idle();
      summary();
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      fails++;
      $display("FAIL watchdog R2: run did not complete, actual timeout expected finish");
      summary();
      $finish;
   end

endmodule